// File: doc/BRIEF.md
# Packed-Halfword Multiply-Accumulate Unit

This execution unit keeps a 40-bit accumulator and adds a signed product to it each time a multiply instruction is issued. Each instruction arrives with two 32-bit operands and a 32-bit instruction word. A two-bit operation field in the word selects one of three arithmetic forms:

- a full 32x32 signed product;
- the sum of two 16x16 signed products, one from the upper halfwords and one from the lower halfwords;
- one 16x16 signed product whose halfwords are picked by two select bits.

Before it executes an instruction, the unit checks a fixed tag field and, for some operations, a reserved field. An encoding that fails either check does not touch the accumulator. Instead the unit raises a one-cycle undefined-instruction pulse, and the surrounding pipeline can turn that pulse into an exception.

The accumulator can be read at any time on its output port. It can be overwritten through a load port, and it can be zeroed with a clear input. All sums wrap modulo 2^40. There is no saturation and no overflow flag. An accepted instruction updates the accumulator on the clock edge where `issue_vld` is sampled high, so the new value is visible in the following cycle.

Top module: `pkmac_top`

## Requirements
- R1: While `rst` is high at a clock edge, the accumulator becomes zero and `undef_pulse` becomes low.
- R2: Operation code 0 (instruction bits [19:18] = 0) adds the product of `opnd_a` and `opnd_b`, both read as signed 32-bit values, to the accumulator.
- R3: Operation code 2 adds two products: signed `opnd_a[31:16]` times signed `opnd_b[31:16]`, plus signed `opnd_a[15:0]` times signed `opnd_b[15:0]`. Each 32-bit product is sign-extended before the two are added in the same cycle.
- R4: Operation code 3 adds one signed 16x16 product. Instruction bit 17 selects the upper (1) or lower (0) half of `opnd_a`. Instruction bit 16 selects the upper (1) or lower (0) half of `opnd_b`.
- R5: An instruction is rejected unless instruction bits [11:4] equal exactly 1.
- R6: An instruction is also rejected in either of these cases: operation code 1, or operation codes 0 and 2 with instruction bits [17:16] not equal to 0.
- R7: A rejected issue leaves the accumulator unchanged and drives `undef_pulse` high for exactly the next cycle. An accepted issue, or a cycle with no issue, leaves `undef_pulse` low.
- R8: Every accumulation wraps modulo 2^40.
- R9: When `clr` is high, the accumulator is zero in the next cycle. This takes priority over a load and over an instruction in the same cycle.
- R10: When `ld_en` is high and `clr` is low, the accumulator takes `ld_val` in the next cycle, even if an instruction is issued in the same cycle. `acc_out` always shows the current accumulator.
- R11: In a cycle with no issue, no load and no clear, the accumulator holds its value.
- R12: Instruction bits [31:20], [15:12] and [3:0] have no effect on the result or on the rejection decision.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| issue_vld | input | 1 | Instruction strobe |
| issue_instr | input | 32 | Instruction word |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| ld_en | input | 1 | Accumulator load enable |
| ld_val | input | 40 | Value to load |
| clr | input | 1 | Accumulator clear |
| acc_out | output | 40 | Current accumulator value |
| undef_pulse | output | 1 | One-cycle flag for a rejected encoding |

## Verification
The properties assume that every input is a known value whenever `rst` is low. They also assume that any cycle in which `clr`, `ld_en` or `issue_vld` is high is fully defined in that same cycle, because the checks relate each accumulator value only to the inputs of the cycle before it. The stimulus meets these assumptions in two ways. First, the driver changes every input on the falling edge, one vector per cycle. Second, between operations it sets `issue_vld`, `ld_en` and `clr` back to zero rather than leaving stale values on them.

// File: rtl/pkmac_pkg.sv
package pkmac_pkg;

    localparam int INSTR_W   = 32;
    localparam int OP_LO     = 18;
    localparam int SEL_LO    = 16;
    localparam int TAG_LO    = 4;
    localparam int TAG_W     = 8;
    localparam logic [TAG_W-1:0] TAG_OK = 8'd1;

    typedef enum logic [1:0] {
        OP_WORD = 2'd0,
        OP_RSVD = 2'd1,
        OP_PAIR = 2'd2,
        OP_PICK = 2'd3
    } mac_op_e;

    typedef struct packed {
        mac_op_e op;
        logic    pick_a_hi;
        logic    pick_b_hi;
        logic    legal;
    } dec_t;

endpackage

// File: rtl/pkmac_decode.sv
module pkmac_decode
    import pkmac_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output dec_t               dec
);
    logic [1:0] sel;
    logic       tag_ok;
    logic       fmt_ok;
    logic       unused_bits;

    // Bits outside the decoded fields deliberately play no role.
    assign unused_bits = ^{instr[31:20], instr[15:12], instr[3:0]};

    always_comb begin
        dec.op        = mac_op_e'(instr[OP_LO +: 2]);
        sel           = instr[SEL_LO +: 2];
        dec.pick_a_hi = sel[1];
        dec.pick_b_hi = sel[0];
        tag_ok        = (instr[TAG_LO +: TAG_W] == TAG_OK);
        unique case (dec.op)
            OP_WORD, OP_PAIR: fmt_ok = (sel == 2'b00);
            OP_PICK:          fmt_ok = 1'b1;
            default:          fmt_ok = 1'b0;
        endcase
        dec.legal = tag_ok && fmt_ok;
    end
endmodule

// File: rtl/pkmac_lane.sv
module pkmac_lane #(
    parameter int HALF_W = 16,
    localparam int PROD_W = 2 * HALF_W
) (
    input  logic [HALF_W-1:0] x,
    input  logic [HALF_W-1:0] y,
    output logic [PROD_W-1:0] p
);
    logic [PROD_W-1:0] xs;
    logic [PROD_W-1:0] ys;

    always_comb begin
        xs = {{HALF_W{x[HALF_W-1]}}, x};
        ys = {{HALF_W{y[HALF_W-1]}}, y};
        p  = xs * ys;
    end
endmodule

// File: rtl/pkmac_datapath.sv
module pkmac_datapath
    import pkmac_pkg::*;
#(
    parameter int ACC_W  = 40,
    parameter int DATA_W = 32,
    localparam int HALF_W = DATA_W / 2,
    localparam int PROD_W = 2 * HALF_W,
    localparam int WIDE_W = 2 * DATA_W,
    localparam int LANES  = 2
) (
    input  dec_t              dec,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    output logic [ACC_W-1:0]  inc
);
    logic [LANES-1:0][HALF_W-1:0] a_half;
    logic [LANES-1:0][HALF_W-1:0] b_half;
    logic [LANES-1:0][PROD_W-1:0] prod;
    logic [LANES-1:0][ACC_W-1:0]  prod_x;
    logic [WIDE_W-1:0]            full_p;
    logic [WIDE_W-1:0]            a_wide;
    logic [WIDE_W-1:0]            b_wide;
    logic                         unused_hi;
    logic                         pick;

    assign pick = (dec.op == OP_PICK);

    // Lane 0 carries the low pair or the picked pair; lane 1 carries the high pair.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        if (g == 0) begin : g_low
            assign a_half[g] = (pick && dec.pick_a_hi) ? opnd_a[DATA_W-1 -: HALF_W]
                                                       : opnd_a[HALF_W-1:0];
            assign b_half[g] = (pick && dec.pick_b_hi) ? opnd_b[DATA_W-1 -: HALF_W]
                                                       : opnd_b[HALF_W-1:0];
        end else begin : g_high
            assign a_half[g] = opnd_a[DATA_W-1 -: HALF_W];
            assign b_half[g] = opnd_b[DATA_W-1 -: HALF_W];
        end
        pkmac_lane #(.HALF_W(HALF_W)) u_lane (
            .x (a_half[g]),
            .y (b_half[g]),
            .p (prod[g])
        );
        assign prod_x[g] = {{(ACC_W-PROD_W){prod[g][PROD_W-1]}}, prod[g]};
    end

    always_comb begin
        a_wide = {{DATA_W{opnd_a[DATA_W-1]}}, opnd_a};
        b_wide = {{DATA_W{opnd_b[DATA_W-1]}}, opnd_b};
        full_p = a_wide * b_wide;
    end

    assign unused_hi = ^full_p[WIDE_W-1:ACC_W];

    always_comb begin
        unique case (dec.op)
            OP_WORD: inc = full_p[ACC_W-1:0];
            OP_PAIR: inc = prod_x[1] + prod_x[0];
            OP_PICK: inc = prod_x[0];
            default: inc = '0;
        endcase
    end
endmodule

// File: rtl/pkmac_top.sv
module pkmac_top
    import pkmac_pkg::*;
#(
    parameter int ACC_W  = 40,
    parameter int DATA_W = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               issue_vld,
    input  logic [INSTR_W-1:0] issue_instr,
    input  logic [DATA_W-1:0]  opnd_a,
    input  logic [DATA_W-1:0]  opnd_b,
    input  logic               ld_en,
    input  logic [ACC_W-1:0]   ld_val,
    input  logic               clr,
    output logic [ACC_W-1:0]   acc_out,
    output logic               undef_pulse
);
    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic             undef;
    } state_t;

    state_t           st_d;
    state_t           st_q;
    dec_t             dec;
    logic [ACC_W-1:0] inc;

    pkmac_decode u_dec (
        .instr (issue_instr),
        .dec   (dec)
    );

    pkmac_datapath #(.ACC_W(ACC_W), .DATA_W(DATA_W)) u_dp (
        .dec    (dec),
        .opnd_a (opnd_a),
        .opnd_b (opnd_b),
        .inc    (inc)
    );

    always_comb begin
        st_d       = st_q;
        st_d.undef = issue_vld && !dec.legal;
        if (clr) begin
            st_d.acc = '0;
        end else if (ld_en) begin
            st_d.acc = ld_val;
        end else if (issue_vld && dec.legal) begin
            st_d.acc = st_q.acc + inc;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_out     = st_q.acc;
    assign undef_pulse = st_q.undef;
endmodule

// File: rtl/pkmac_checks.sv
module pkmac_checks
    import pkmac_pkg::*;
#(
    parameter int ACC_W  = 40,
    parameter int DATA_W = 32
) (
    input logic               clk,
    input logic               rst,
    input logic               issue_vld,
    input logic [INSTR_W-1:0] issue_instr,
    input logic [DATA_W-1:0]  opnd_a,
    input logic [DATA_W-1:0]  opnd_b,
    input logic               ld_en,
    input logic [ACC_W-1:0]   ld_val,
    input logic               clr,
    input logic [ACC_W-1:0]   acc_out,
    input logic               undef_pulse
);
    p_reset_zero_r1: assert property (@(posedge clk)
        rst |=> (acc_out == '0 && !undef_pulse));

    p_bad_tag_r5: assert property (@(posedge clk) disable iff (rst)
        (issue_vld && issue_instr[TAG_LO +: TAG_W] != TAG_OK) |=> undef_pulse);

    p_rsvd_op_r6: assert property (@(posedge clk) disable iff (rst)
        (issue_vld && issue_instr[OP_LO +: 2] == 2'd1) |=> undef_pulse);

    p_rsvd_sel_r6: assert property (@(posedge clk) disable iff (rst)
        (issue_vld && !issue_instr[OP_LO] && issue_instr[SEL_LO +: 2] != 2'd0)
        |=> undef_pulse);

    p_no_issue_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        !issue_vld |=> !undef_pulse);

    p_reject_holds_r7: assert property (@(posedge clk) disable iff (rst)
        (!ld_en && !clr && issue_vld && issue_instr[OP_LO +: 2] == 2'd1)
        |=> $stable(acc_out));

    p_clear_first_r9: assert property (@(posedge clk) disable iff (rst)
        clr |=> (acc_out == '0));

    p_load_value_r10: assert property (@(posedge clk) disable iff (rst)
        (ld_en && !clr) |=> (acc_out == $past(ld_val)));

    p_idle_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (!issue_vld && !ld_en && !clr) |=> $stable(acc_out));
endmodule

bind pkmac_top pkmac_checks #(.ACC_W(ACC_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_pkmac_top.sv
module sim_pkmac_top;
    localparam int  ACC_W    = 40;
    localparam int  DATA_W   = 32;
    localparam time HALF_PER = 10ns;

    typedef struct {
        logic [ACC_W-1:0] acc;
        logic             undef;
        string            req;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              issue_vld = 1'b0;
    logic [31:0]       issue_instr = '0;
    logic [DATA_W-1:0] opnd_a = '0;
    logic [DATA_W-1:0] opnd_b = '0;
    logic              ld_en = 1'b0;
    logic [ACC_W-1:0]  ld_val = '0;
    logic              clr = 1'b0;
    logic [ACC_W-1:0]  acc_out;
    logic              undef_pulse;

    exp_t             sb[$];
    logic [ACC_W-1:0] acc_m = '0;
    int               n_vec = 0;
    int               n_bad = 0;
    bit               done = 1'b0;

    always #HALF_PER clk = ~clk;

    pkmac_top #(.ACC_W(ACC_W), .DATA_W(DATA_W)) u0 (
        .clk(clk), .rst(rst), .issue_vld(issue_vld), .issue_instr(issue_instr),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .ld_en(ld_en), .ld_val(ld_val),
        .clr(clr), .acc_out(acc_out), .undef_pulse(undef_pulse)
    );

    function automatic logic [31:0] mk(input logic [1:0] op, input logic [1:0] sel,
                                       input logic [7:0] tag, input logic [19:0] junk);
        return {junk[19:8], op, sel, junk[7:4], tag, junk[3:0]};
    endfunction

    function automatic bit legal_m(input logic [31:0] ins);
        if (ins[11:4] != 8'd1) return 1'b0;
        if (ins[19:18] == 2'd3) return 1'b1;
        if (ins[19:18] == 2'd1) return 1'b0;
        return ins[17:16] == 2'd0;
    endfunction

    function automatic logic [ACC_W-1:0] inc_m(input logic [31:0] ins,
                                               input logic [31:0] a, input logic [31:0] b);
        longint r;
        longint x;
        longint y;
        case (ins[19:18])
            2'd0: r = longint'($signed(a)) * longint'($signed(b));
            2'd2: r = longint'($signed(a[31:16])) * longint'($signed(b[31:16]))
                    + longint'($signed(a[15:0])) * longint'($signed(b[15:0]));
            default: begin
                x = ins[17] ? longint'($signed(a[31:16])) : longint'($signed(a[15:0]));
                y = ins[16] ? longint'($signed(b[31:16])) : longint'($signed(b[15:0]));
                r = x * y;
            end
        endcase
        return r[ACC_W-1:0];
    endfunction

    task automatic step(input bit r, input bit v, input logic [31:0] ins,
                        input logic [31:0] a, input logic [31:0] b,
                        input bit ld, input logic [ACC_W-1:0] lv, input bit c,
                        input string req);
        exp_t e;
        @(negedge clk);
        rst = r; issue_vld = v; issue_instr = ins; opnd_a = a; opnd_b = b;
        ld_en = ld; ld_val = lv; clr = c;
        if (r) begin
            acc_m   = '0;
            e.undef = 1'b0;
        end else begin
            e.undef = v && !legal_m(ins);
            if (c) acc_m = '0;
            else if (ld) acc_m = lv;
            else if (v && legal_m(ins)) acc_m = acc_m + inc_m(ins, a, b);
        end
        e.acc = acc_m;
        e.req = req;
        sb.push_back(e);
    endtask

    task automatic issue(input logic [31:0] ins, input logic [31:0] a,
                         input logic [31:0] b, input string req);
        step(1'b0, 1'b1, ins, a, b, 1'b0, '0, 1'b0, req);
    endtask

    task automatic load(input logic [ACC_W-1:0] v, input string req);
        step(1'b0, 1'b0, '0, '0, '0, 1'b1, v, 1'b0, req);
    endtask

    task automatic idle(input string req);
        step(1'b0, 1'b0, '0, '0, '0, 1'b0, '0, 1'b0, req);
    endtask

    // Monitor: one expected item per driven cycle, compared after the edge.
    initial begin
        forever begin
            @(posedge clk);
            #2ns;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                n_vec++;
                if (acc_out !== e.acc || undef_pulse !== e.undef) begin
                    n_bad++;
                    $display("FAIL %s: acc=%h undef=%b expected acc=%h undef=%b",
                             e.req, acc_out, undef_pulse, e.acc, e.undef);
                end
            end
        end
    end

    initial begin
        #(HALF_PER * 2 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: acc=%h undef=%b expected run to complete",
                     acc_out, undef_pulse);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        step(1'b1, 1'b0, '0, '0, '0, 1'b0, '0, 1'b0, "R1");
        step(1'b1, 1'b1, mk(2'd1, 2'd0, 8'd1, '0), 32'h5, 32'h7, 1'b1, 40'h12, 1'b0, "R1");
        idle("R1");
        // R2 full-word signed product
        issue(mk(2'd0, 2'd0, 8'd1, '0), 32'hFFFF_FFFD, 32'd7, "R2");
        issue(mk(2'd0, 2'd0, 8'd1, '0), 32'h8000_0000, 32'h0000_0003, "R2");
        // R8 wrap on large products
        issue(mk(2'd0, 2'd0, 8'd1, '0), 32'h7FFF_FFFF, 32'h7FFF_FFFF, "R8");
        issue(mk(2'd0, 2'd0, 8'd1, '0), 32'h8000_0000, 32'h8000_0000, "R8");
        // R3 dual halfword, mixed signs
        issue(mk(2'd2, 2'd0, 8'd1, '0), 32'hFFFE_0003, 32'h0005_FFF9, "R3");
        issue(mk(2'd2, 2'd0, 8'd1, '0), 32'h8000_8000, 32'h8000_7FFF, "R3");
        // R4 all four halfword picks
        for (int s = 0; s < 4; s++)
            issue(mk(2'd3, 2'(s), 8'd1, '0), 32'hFFF3_0011, 32'h0009_FFFB, "R4");
        // R5 bad tag values
        issue(mk(2'd0, 2'd0, 8'd0, '0), 32'd9, 32'd9, "R5");
        issue(mk(2'd3, 2'd0, 8'd2, '0), 32'd9, 32'd9, "R5");
        issue(mk(2'd2, 2'd0, 8'h81, '0), 32'd9, 32'd9, "R5");
        idle("R7");
        // R6 reserved operation and reserved select bits
        issue(mk(2'd1, 2'd0, 8'd1, '0), 32'd9, 32'd9, "R6");
        for (int s = 1; s < 4; s++) begin
            issue(mk(2'd0, 2'(s), 8'd1, '0), 32'd9, 32'd9, "R6");
            issue(mk(2'd2, 2'(s), 8'd1, '0), 32'd9, 32'd9, "R6");
        end
        // R7 reject then accept back to back
        issue(mk(2'd1, 2'd3, 8'd1, '0), 32'd4, 32'd4, "R7");
        issue(mk(2'd3, 2'd0, 8'd1, '0), 32'd4, 32'd4, "R7");
        // R8 wrap across the top of the accumulator
        load(40'h7F_FFFF_FFFF, "R10");
        issue(mk(2'd3, 2'd0, 8'd1, '0), 32'd1, 32'd1, "R8");
        load(40'hFF_FFFF_FFFF, "R10");
        issue(mk(2'd3, 2'd0, 8'd1, '0), 32'd1, 32'd1, "R8");
        // R10 load beats a valid and an invalid issue
        step(1'b0, 1'b1, mk(2'd0, 2'd0, 8'd1, '0), 32'd5, 32'd5, 1'b1, 40'h12_3456_789A, 1'b0, "R10");
        step(1'b0, 1'b1, mk(2'd1, 2'd0, 8'd1, '0), 32'd5, 32'd5, 1'b1, 40'h00_0000_0042, 1'b0, "R10");
        // R9 clear beats load and issue
        step(1'b0, 1'b1, mk(2'd0, 2'd0, 8'd1, '0), 32'd5, 32'd5, 1'b1, 40'h55, 1'b1, "R9");
        // R11 idle hold
        load(40'hA5_5A5A_A5A5, "R10");
        idle("R11");
        idle("R11");
        // R12 junk in the ignored bit ranges
        issue(mk(2'd2, 2'd0, 8'd1, 20'hFFFFF), 32'h0010_FFFF, 32'hFFF0_0002, "R12");
        issue(mk(2'd3, 2'd2, 8'd1, 20'h5A5A5), 32'h0010_FFFF, 32'hFFF0_0002, "R12");
        issue(mk(2'd1, 2'd0, 8'd1, 20'hFFFFF), 32'd3, 32'd3, "R12");
        // Mixed random traffic across all operations
        for (int i = 0; i < 300; i++) begin
            logic [7:0] tg;
            tg = ($urandom_range(0, 7) == 0) ? 8'($urandom) : 8'd1;
            if ($urandom_range(0, 15) == 0)
                load({8'($urandom), 32'($urandom)}, "R10");
            else
                issue(mk(2'($urandom), 2'($urandom), tg, 20'($urandom)),
                      32'($urandom), 32'($urandom), "R2");
        end
        idle("R11");
        idle("R11");
        wait (sb.size() == 0);
        @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule